// File: doc/BRIEF.md
# Header-Relative Word Extractor

This block lifts up to nine 16-bit words out of a received Ethernet frame so that a downstream classifier can build its lookup key from them. Each word is addressed not by an absolute position in the frame but by an even byte distance from one of two parsed boundaries: the first byte after the link-layer header or the first byte after the network-layer header. A separate parser supplies both boundary positions with the first byte of the frame. The word slots are configured through a small table of descriptors. The table holds several slices, and one slice is chosen per frame.

Bytes arrive one per valid beat, with start and end markers. The block compares every byte position against the target of each slot and latches the two bytes of each selected word. On the last byte it publishes all the words, one valid bit per slot, and a contiguous mask whose length is the number of configured slots. A one-cycle done strobe accompanies the publication. The published values are held until the next frame ends.

Top module: `hdr_word_extractor`

## Requirements
- R1: After reset every output is zero, every descriptor is zero, and a frame processed with the reset table yields an empty mask, no valid bits and zero words.
- R2: A descriptor whose bits [7:5] are 001 selects the word whose first byte sits at position l2_end + 2*index, where the index is bits [4:0] and byte position 0 is the start beat. The byte at that position appears in bits [15:8] of the slot's word and the byte after it in bits [7:0].
- R3: A descriptor whose bits [7:5] are 010 selects the word at l3_end + 2*index, with the same byte order as R2.
- R4: A slot whose descriptor is zero is disabled: its valid bit is clear, its word is zero, and it is not counted in the mask.
- R5: out_cfg_mask has its lowest N bits set, where N is the number of non-zero descriptors in the chosen slice as they stood at the start beat.
- R6: If either byte of a selected word lies at or beyond the frame length, the slot's valid bit is clear and its word is zero.
- R7: out_done is high for exactly one cycle, in the cycle after the end beat. The words, the valid bits and the mask change only in that cycle and hold their values until the next end beat.
- R8: Descriptor register address = slice*16 + slot, with slice taken from in_slice at the start beat. Writes to slot numbers 9 to 15 of a stride, or to a slice beyond the last one, change nothing.
- R9: A descriptor write during a frame does not affect that frame. It applies from the next start beat on.
- R10: Only bits [7:0] of a descriptor write are stored. A non-zero descriptor whose selector is neither 001 nor 010 is counted in the mask, but its slot is never valid.
- R11: Cycles with in_valid low do not advance the byte position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write enable |
| cfg_addr | input | 8 | Descriptor address, slice*16 + slot |
| cfg_wdata | input | 32 | Descriptor write data; bits [7:0] are stored |
| in_valid | input | 1 | Byte beat valid |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_eof | input | 1 | Beat is the last byte of a frame |
| in_byte | input | 8 | Frame byte |
| in_slice | input | 1 | Descriptor slice to use, sampled at the start beat |
| l2_end | input | 11 | Position of the first byte after the link header, sampled at the start beat |
| l3_end | input | 11 | Position of the first byte after the network header, sampled at the start beat |
| out_words | output | 144 | Captured words; slot k in bits [16k+15:16k] |
| out_valid | output | 9 | Per-slot valid bits |
| out_cfg_mask | output | 9 | Contiguous mask of configured slots |
| out_done | output | 1 | One-cycle strobe after the end beat |

## Verification
The hardest case to reach from the ports is a descriptor rewrite that lands in the middle of a frame. The rewrite must not disturb that frame's targets, and it must take effect on the next frame. The bench drives a register write on the same beat as a mid-frame byte, predicts the result from a copy of the table taken at the start beat, and then checks the following frame against the updated table. Frames that end inside a selected word, single-byte frames, and beats separated by idle gaps are mixed into the random traffic to cover the truncation and position-count cases.

// File: rtl/hwx_pkg.sv
package hwx_pkg;
   localparam logic [2:0] SEL_L2 = 3'b001;
   localparam logic [2:0] SEL_L3 = 3'b010;

   typedef struct packed {
      logic [2:0] sel;
      logic [4:0] idx;
   } desc_t;
endpackage

// File: rtl/hwx_desc_table.sv
module hwx_desc_table #(
   parameter int NUM_SLICES   = 2,
   parameter int NUM_SLOTS    = 9,
   parameter int SLICE_STRIDE = 16,
   parameter int ADDR_W       = 8,
   parameter int SLICE_W      = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [7:0]               wdata,
   input  logic [SLICE_W-1:0]       rd_slice,
   output logic [NUM_SLOTS*8-1:0]   rd_descs
);
   localparam int SLICE_BITS = NUM_SLOTS * 8;

   logic [NUM_SLICES*SLICE_BITS-1:0] cells;

   for (genvar sl = 0; sl < NUM_SLICES; sl++) begin : g_slice
      for (genvar so = 0; so < NUM_SLOTS; so++) begin : g_slot
         localparam logic [ADDR_W-1:0] CELL_ADDR = ADDR_W'(sl * SLICE_STRIDE + so);
         logic [7:0] cell_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cell_q <= '0;
            else if (we && addr == CELL_ADDR)
               cell_q <= wdata;
         end
         assign cells[(sl*NUM_SLOTS+so)*8 +: 8] = cell_q;
      end
   end

   always_comb begin
      rd_descs = '0;
      for (int sl = 0; sl < NUM_SLICES; sl++)
         if (rd_slice == SLICE_W'(sl))
            rd_descs = cells[sl*SLICE_BITS +: SLICE_BITS];
   end
endmodule

// File: rtl/hwx_mask_gen.sv
module hwx_mask_gen #(
   parameter int NUM_SLOTS = 9,
   parameter int CNT_W     = 4
) (
   input  logic [CNT_W-1:0]     count,
   output logic [NUM_SLOTS-1:0] mask
);
   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_bit
      assign mask[i] = (count > CNT_W'(i));
   end
endmodule

// File: rtl/hwx_slot.sv
module hwx_slot #(
   parameter int POS_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             beat,
   input  logic             last,
   input  logic [POS_W:0]   pos,
   input  logic [7:0]       desc_in,
   input  logic [POS_W-1:0] l2_end,
   input  logic [POS_W-1:0] l3_end,
   input  logic [7:0]       byte_in,
   output logic [15:0]      word_o,
   output logic             valid_o
);
   import hwx_pkg::*;
   localparam int PW = POS_W + 1;

   desc_t          d;
   logic [PW-1:0]  tgt_new, tgt_q, tgt;
   logic           en_new, en_q, en;
   logic           hit_hi, hit_lo, got_hi, got_lo, got_hi_q, got_lo_q;
   logic [7:0]     hi_q, lo_q, hi_n, lo_n;

   assign d       = desc_t'(desc_in);
   assign en_new  = (d.sel == SEL_L2) || (d.sel == SEL_L3);
   assign tgt_new = ((d.sel == SEL_L2) ? PW'(l2_end) : PW'(l3_end)) + PW'({d.idx, 1'b0});
   assign tgt     = start ? tgt_new : tgt_q;
   assign en      = start ? en_new  : en_q;
   assign hit_hi  = beat && en && (pos == tgt);
   assign hit_lo  = beat && en && (pos == tgt + PW'(1));
   assign got_hi  = (!start && got_hi_q) || hit_hi;
   assign got_lo  = (!start && got_lo_q) || hit_lo;
   assign hi_n    = hit_hi ? byte_in : hi_q;
   assign lo_n    = hit_lo ? byte_in : lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_q    <= '0;
         en_q     <= 1'b0;
         got_hi_q <= 1'b0;
         got_lo_q <= 1'b0;
         hi_q     <= '0;
         lo_q     <= '0;
         word_o   <= '0;
         valid_o  <= 1'b0;
      end else begin
         if (beat) begin
            tgt_q    <= tgt;
            en_q     <= en;
            got_hi_q <= got_hi;
            got_lo_q <= got_lo;
            hi_q     <= hi_n;
            lo_q     <= lo_n;
         end
         if (last) begin
            valid_o <= got_hi && got_lo;
            word_o  <= (got_hi && got_lo) ? {hi_n, lo_n} : 16'h0000;
         end
      end
   end
endmodule

// File: rtl/hdr_word_extractor.sv
module hdr_word_extractor #(
   parameter int NUM_SLICES   = 2,
   parameter int NUM_SLOTS    = 9,
   parameter int SLICE_STRIDE = 16,
   parameter int ADDR_W       = 8,
   parameter int POS_W        = 11,
   localparam int SLICE_W     = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [ADDR_W-1:0]       cfg_addr,
   input  logic [31:0]             cfg_wdata,
   input  logic                    in_valid,
   input  logic                    in_sof,
   input  logic                    in_eof,
   input  logic [7:0]              in_byte,
   input  logic [SLICE_W-1:0]      in_slice,
   input  logic [POS_W-1:0]        l2_end,
   input  logic [POS_W-1:0]        l3_end,
   output logic [NUM_SLOTS*16-1:0] out_words,
   output logic [NUM_SLOTS-1:0]    out_valid,
   output logic [NUM_SLOTS-1:0]    out_cfg_mask,
   output logic                    out_done
);
   localparam int CNT_W = $clog2(NUM_SLOTS + 1);
   localparam int PW    = POS_W + 1;

   if (NUM_SLOTS < 1 || NUM_SLOTS > SLICE_STRIDE) begin : g_bad_slots
      $error("NUM_SLOTS must be between 1 and SLICE_STRIDE");
   end
   if (NUM_SLICES * SLICE_STRIDE > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for NUM_SLICES * SLICE_STRIDE");
   end
   if (POS_W < 6) begin : g_bad_pos
      $error("POS_W must be at least 6");
   end

   logic                   start, beat, last, in_frame_q;
   logic [PW-1:0]          cnt_q, pos;
   logic [NUM_SLOTS*8-1:0] descs;
   logic [CNT_W-1:0]       cfg_cnt_new, cfg_cnt_q, cfg_cnt;
   logic [NUM_SLOTS-1:0]   mask_now;

   assign start = in_valid && in_sof;
   assign beat  = in_valid && (in_sof || in_frame_q);
   assign last  = beat && in_eof;
   assign pos   = start ? '0 : cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         in_frame_q <= 1'b0;
         cfg_cnt_q  <= '0;
      end else begin
         if (beat)  cnt_q     <= (&pos) ? pos : pos + PW'(1);
         if (start) cfg_cnt_q <= cfg_cnt_new;
         if (last)       in_frame_q <= 1'b0;
         else if (start) in_frame_q <= 1'b1;
      end
   end

   hwx_desc_table #(
      .NUM_SLICES(NUM_SLICES), .NUM_SLOTS(NUM_SLOTS), .SLICE_STRIDE(SLICE_STRIDE),
      .ADDR_W(ADDR_W), .SLICE_W(SLICE_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata[7:0]),
      .rd_slice(in_slice), .rd_descs(descs)
   );

   always_comb begin
      cfg_cnt_new = '0;
      for (int s = 0; s < NUM_SLOTS; s++)
         if (descs[s*8 +: 8] != 8'h00) cfg_cnt_new = cfg_cnt_new + CNT_W'(1);
   end
   assign cfg_cnt = start ? cfg_cnt_new : cfg_cnt_q;

   hwx_mask_gen #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_mask (
      .count(cfg_cnt), .mask(mask_now)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_cfg_mask <= '0;
         out_done     <= 1'b0;
      end else begin
         out_done <= last;
         if (last) out_cfg_mask <= mask_now;
      end
   end

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      hwx_slot #(.POS_W(POS_W)) u_slot (
         .clk(clk), .rst_n(rst_n), .start(start), .beat(beat), .last(last),
         .pos(pos), .desc_in(descs[s*8 +: 8]), .l2_end(l2_end), .l3_end(l3_end),
         .byte_in(in_byte), .word_o(out_words[s*16 +: 16]), .valid_o(out_valid[s])
      );
   end
endmodule

// File: rtl/hwx_checker.sv
module hwx_checker #(
   parameter int NUM_SLOTS = 9
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    in_eof,
   input logic [NUM_SLOTS*16-1:0] out_words,
   input logic [NUM_SLOTS-1:0]    out_valid,
   input logic [NUM_SLOTS-1:0]    out_cfg_mask,
   input logic                    out_done
);
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |=> !out_done);

   p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |-> $past(in_valid && in_eof));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_done |-> ($stable(out_words) && $stable(out_valid) && $stable(out_cfg_mask)));

   p_mask_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_cfg_mask + NUM_SLOTS'(1)) & out_cfg_mask) == '0);

   p_valid_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(out_valid) <= $countones(out_cfg_mask));

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_w
      p_zero_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !out_valid[i] |-> (out_words[i*16 +: 16] == 16'h0000));
   end
endmodule

bind hdr_word_extractor hwx_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eof(in_eof),
   .out_words(out_words), .out_valid(out_valid), .out_cfg_mask(out_cfg_mask),
   .out_done(out_done)
);

// File: tb/sim_hdr_word_extractor.sv
module sim_hdr_word_extractor;
   localparam int CLK_P = 10;
   localparam int NSL   = 2;
   localparam int NS    = 9;
   localparam int WW    = NS * 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [7:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
   logic [7:0] in_byte = '0;
   logic [0:0] in_slice = '0;
   logic [10:0] l2_end = '0, l3_end = '0;
   logic [WW-1:0] out_words;
   logic [NS-1:0] out_valid, out_cfg_mask;
   logic out_done;

   hdr_word_extractor u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_byte(in_byte),
      .in_slice(in_slice), .l2_end(l2_end), .l3_end(l3_end),
      .out_words(out_words), .out_valid(out_valid), .out_cfg_mask(out_cfg_mask),
      .out_done(out_done)
   );

   always #(CLK_P/2) clk = ~clk;

   int total = 0, bad = 0;
   logic [7:0] desc_m [NSL][NS];
   logic [7:0] snap [NS];
   logic [7:0] frm [256];
   logic [WW-1:0] exp_w;
   logic [NS-1:0] exp_v, exp_m;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [WW-1:0] act, input logic [WW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int addr, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 8'(addr); cfg_wdata = d;
      if ((addr % 16) < NS && (addr / 16) < NSL) desc_m[addr/16][addr%16] = d[7:0];
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // expected outputs from the requirements (R2..R6, R10)
   task automatic predict(input int len, input int l2, input int l3);
      int n;
      exp_w = '0; exp_v = '0; n = 0;
      for (int s = 0; s < NS; s++) begin
         logic [7:0] d;
         int p;
         d = snap[s];
         if (d != 8'h00) n++;
         if (d[7:5] == 3'b001 || d[7:5] == 3'b010) begin
            p = ((d[7:5] == 3'b001) ? l2 : l3) + 2 * int'(d[4:0]);
            if (p + 1 < len) begin
               exp_v[s] = 1'b1;
               exp_w[s*16 +: 16] = {frm[p], frm[p+1]};
            end
         end
      end
      exp_m = '0;
      for (int s = 0; s < NS; s++) if (s < n) exp_m[s] = 1'b1;
   endtask

   task automatic send(input int sl, input int len, input int l2, input int l3,
                       input bit gaps, input bit midwr, input string req);
      logic [7:0] newv;
      logic [WW-1:0] held;
      for (int s = 0; s < NS; s++) snap[s] = (sl < NSL) ? desc_m[sl][s] : 8'h00;
      newv = snap[0] ^ 8'h21;
      for (int b = 0; b < len; b++) begin
         if (gaps && ($urandom % 3) == 0) begin
            @(negedge clk);
            cfg_we = 1'b0; in_valid = 1'b0;
         end
         @(negedge clk);
         cfg_we = 1'b0;
         in_valid = 1'b1; in_sof = (b == 0); in_eof = (b == len - 1); in_byte = frm[b];
         in_slice = 1'(sl); l2_end = 11'(l2); l3_end = 11'(l3);
         if (midwr && b == len / 2) begin
            cfg_we = 1'b1; cfg_addr = 8'(sl * 16); cfg_wdata = {24'h0, newv};
            desc_m[sl][0] = newv;
         end
      end
      @(negedge clk);
      cfg_we = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      in_l2_garble();
      predict(len, l2, l3);
      chk(out_done === 1'b1, "R7", "done after end beat", WW'(out_done), WW'(1));
      chk(out_words === exp_w, req, "words", out_words, exp_w);
      chk(out_valid === exp_v, req, "valid", WW'(out_valid), WW'(exp_v));
      chk(out_cfg_mask === exp_m, "R5", "cfg mask", WW'(out_cfg_mask), WW'(exp_m));
      held = out_words;
      @(negedge clk);
      chk(out_done === 1'b0, "R7", "done single cycle", WW'(out_done), WW'(0));
      chk(out_words === held, "R7", "words held", out_words, held);
   endtask

   // boundary inputs change after the start beat; R8 says they are sampled there only
   task automatic in_l2_garble();
      l2_end = 11'($urandom); l3_end = 11'($urandom); in_slice = 1'($urandom);
   endtask

   task automatic fill(input int len);
      for (int b = 0; b < 256; b++) frm[b] = (b < len) ? 8'($urandom) : 8'h00;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      for (int a = 0; a < NSL; a++) for (int s = 0; s < NS; s++) desc_m[a][s] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(out_words === '0, "R1", "words at reset", out_words, '0);
      chk(out_valid === '0, "R1", "valid at reset", WW'(out_valid), '0);
      chk(out_cfg_mask === '0, "R1", "mask at reset", WW'(out_cfg_mask), '0);
      chk(out_done === 1'b0, "R1", "done at reset", WW'(out_done), '0);
      fill(40);
      send(0, 40, 14, 34, 0, 0, "R1");

      // R2 R3 R10: address/port layout in slice 1, junk in upper write bits
      wr(16 + 0, 32'hFFFF_FF26); wr(16 + 1, 32'h1234_0027);
      wr(16 + 2, 32'h0000_0028); wr(16 + 3, 32'h0000_0029);
      wr(16 + 4, 32'hABCD_EF40); wr(16 + 5, 32'h0000_0041);
      fill(64);
      send(1, 64, 14, 34, 0, 0, "R2");
      send(1, 64, 18, 38, 1, 0, "R3");
      // R6: frame ends inside the destination-port word and before it
      fill(37);
      send(1, 37, 14, 34, 0, 0, "R6");
      fill(36);
      send(1, 36, 14, 34, 0, 0, "R6");
      // R4: slice 0 still empty while slice 1 is configured
      send(0, 36, 14, 34, 0, 0, "R4");
      // R8: out-of-range writes change nothing
      wr(9, 32'h21); wr(15, 32'h22); wr(2 * 16 + 1, 32'h23);
      send(0, 36, 14, 34, 0, 0, "R8");
      // R10: unknown selector counted but never valid; zero slot in between (R4)
      wr(0, 32'h21); wr(2, 32'h65); wr(4, 32'h42);
      fill(50);
      send(0, 50, 12, 30, 0, 0, "R10");
      // single-byte frame, start and end on one beat (R6)
      wr(1, 32'h20);
      fill(1);
      send(0, 1, 0, 0, 0, 0, "R6");
      fill(2);
      send(0, 2, 0, 0, 0, 0, "R2");
      // R9: rewrite during a frame, then confirm the new value on the next frame
      fill(60);
      send(0, 60, 10, 30, 0, 1, "R9");
      send(0, 60, 10, 30, 0, 0, "R9");
      // R11: idle gaps between beats
      send(1, 60, 14, 34, 1, 0, "R11");

      // random traffic
      for (int it = 0; it < 300; it++) begin
         int len, l2, l3, sl;
         if (($urandom % 4) == 0) begin
            int a;
            a = ($urandom % 2) * 16 + ($urandom % 16);
            case ($urandom % 4)
               0: wr(a, 32'h0);
               1: wr(a, {$urandom, 3'b001, 5'($urandom)} & 32'hFFFF_FF3F | 32'h20);
               2: wr(a, {24'($urandom), 3'b010, 5'($urandom % 8)});
               default: wr(a, $urandom);
            endcase
         end
         len = 1 + ($urandom % 100);
         l2  = 6 + ($urandom % 25);
         l3  = l2 + ($urandom % 41);
         sl  = $urandom % 2;
         fill(len);
         send(sl, len, l2, l3, ($urandom % 2) == 1, ($urandom % 8) == 0,
              (it % 2 == 0) ? "R2" : "R3");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule